// File: doc/BRIEF.md
# Comb Decimator for One-Bit Oversampled Streams

This block turns the one-bit output of an oversampling noise-shaping modulator into multi-bit words at a reduced rate. Every clock delivers one input bit. The block reads a 1 as +1 and a 0 as -1. It integrates that value at the full rate, then takes differences once per decimation window. The result is the moving-sum response ((1 - z^-D)/(1 - z^-1))^N, sampled every D input clocks. The design needs no multipliers.

The filter order N is a parameter from 1 to 3. As a rule of thumb, choose N one higher than the order of the modulator that feeds the block. A second-order modulator therefore pairs with the default N = 3. The decimation ratio D defaults to 64 and must be a power of two.

When N = 1 the block is a plain accumulate-and-dump: the accumulator is latched and cleared at every window boundary. For larger N it uses a cascade of integrators followed by a cascade of differencers that run at the low rate. The output register is 2 + N·log2(D) bits wide. That width holds the full-scale value ±D^N exactly, so the output never wraps. The integrators are allowed to wrap silently.

Top module: `cic_decimator`

## Requirements
- R1: An input bit of 1 counts as +1 and a bit of 0 counts as -1. A stream of only ones settles to +D^N and a stream of only zeros settles to -D^N.
- R2: Each valid word equals the sum over j of h[j]·x[t-j], where h is the N-fold self-convolution of a length-D box of ones, t is the index of the last sample of the window, and samples before reset count as zero.
- R3: `out_word` is 2 + N·log2(D) bits wide in two's complement, and every valid word lies within ±D^N with no wrap-around.
- R4: `out_valid` is high for exactly one clock. It rises in the clock after every D-th sample consumed since reset, and at no other time.
- R5: The first N-1 window boundaries after reset produce no strobe. From boundary N onward, every boundary produces one.
- R6: `out_word` changes only together with a strobe. It reads 0 from reset until the first strobe.
- R7: A synchronous, active-high reset clears all state. Sampling restarts with the first clock after reset is released, including when the reset arrives in the middle of a stream.
- R8: With N = 1, each output is the signed count of the D samples in its own window only, independent of earlier windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input-rate clock; one bit is consumed per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_bit | input | 1 | Modulator bit; 1 means +1, 0 means -1 |
| out_word | output | 2+N·log2(D) | Signed decimated result, held between strobes |
| out_valid | output | 1 | One-clock strobe marking a new result |

## Verification
The checker watches the timing of the strobe on every cycle:
- It checks the spacing of D clocks from reset, the single-cycle pulse and the suppressed boundaries during fill.
- It checks that the word holds between strobes, that reset clears the outputs, and that no valid word goes past ±D^N.

The numeric value of each word can only be shown by the bench. It compares each word against a direct convolution of the recorded bit history with the N-fold box response. The stimulus covers constant, alternating and random-density streams and a reset in the middle of a stream. The bench runs all three orders side by side, which covers the dump variant against the integrator-differencer variant.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // Register width that holds +/- decim**order without wrap-around
  function automatic int cic_width(input int order, input int decim);
    return 2 + order * $clog2(decim);
  endfunction
endpackage

// File: rtl/cic_phase.sv
module cic_phase #(
  parameter int DECIM = 64,
  parameter int ORDER = 3
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic emit
);
  localparam int CW = $clog2(DECIM);
  localparam int FW = (ORDER > 1) ? $clog2(ORDER) : 1;

  logic [CW-1:0] cnt;
  logic [FW-1:0] fill;
  logic          full;

  assign tick = (cnt == CW'(DECIM - 1));
  assign full = (fill == FW'(ORDER - 1));
  assign emit = tick && full;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      fill <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick && !full) fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/cic_integrators.sv
module cic_integrators #(
  parameter int ORDER = 3,
  parameter int W     = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dump,
  input  logic signed [W-1:0] x_in,
  output logic signed [W-1:0] sum_next
);
  logic signed [W-1:0] acc [ORDER];
  logic signed [W-1:0] nxt [ORDER];

  for (genvar k = 0; k < ORDER; k++) begin : g_int
    if (k == 0) begin : g_first
      assign nxt[k] = acc[k] + x_in;
    end else begin : g_chain
      assign nxt[k] = acc[k] + nxt[k-1];
    end
    always_ff @(posedge clk) begin
      if (rst || dump) acc[k] <= '0;
      else             acc[k] <= nxt[k];
    end
  end

  assign sum_next = nxt[ORDER-1];
endmodule

// File: rtl/cic_combs.sv
module cic_combs #(
  parameter int ORDER = 3,
  parameter int W     = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  if (ORDER == 1) begin : g_pass
    assign dout = din;
  end else begin : g_comb
    logic signed [W-1:0] stg [ORDER+1];
    logic signed [W-1:0] dly [ORDER];
    assign stg[0] = din;
    for (genvar k = 0; k < ORDER; k++) begin : g_stage
      assign stg[k+1] = stg[k] - dly[k];
      always_ff @(posedge clk) begin
        if (rst)       dly[k] <= '0;
        else if (tick) dly[k] <= stg[k];
      end
    end
    assign dout = stg[ORDER];
  end
endmodule

// File: rtl/cic_decimator.sv
module cic_decimator
  import cic_pkg::*;
#(
  parameter int ORDER = 3,
  parameter int DECIM = 64,
  localparam int W    = cic_width(ORDER, DECIM)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_bit,
  output logic signed [W-1:0] out_word,
  output logic                out_valid
);
  localparam bit DUMP_MODE = (ORDER == 1);

  logic                tick;
  logic                emit;
  logic signed [W-1:0] x_s;
  logic signed [W-1:0] integ;
  logic signed [W-1:0] result;

  assign x_s = in_bit ? W'(1) : '1;

  cic_phase #(.DECIM(DECIM), .ORDER(ORDER)) u_phase (
    .clk(clk), .rst(rst), .tick(tick), .emit(emit)
  );

  cic_integrators #(.ORDER(ORDER), .W(W)) u_int (
    .clk(clk), .rst(rst), .dump(DUMP_MODE && tick),
    .x_in(x_s), .sum_next(integ)
  );

  cic_combs #(.ORDER(ORDER), .W(W)) u_comb (
    .clk(clk), .rst(rst), .tick(tick), .din(integ), .dout(result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) out_word <= result;
    end
  end
endmodule

// File: rtl/cic_decimator_chk.sv
module cic_decimator_chk #(
  parameter int ORDER = 3,
  parameter int DECIM = 64,
  parameter int W     = 20
) (
  input logic                clk,
  input logic                rst,
  input logic signed [W-1:0] out_word,
  input logic                out_valid
);
  localparam int LOG2D = $clog2(DECIM);
  localparam logic signed [W-1:0] FULL = W'(1) << (ORDER * LOG2D);

  logic [LOG2D-1:0] ck;
  logic [1:0]       win;
  logic             past_ok = 1'b0;

  always_ff @(posedge clk) begin
    past_ok <= !rst;
    if (rst) begin
      ck  <= '0;
      win <= '0;
    end else begin
      ck <= (ck == LOG2D'(DECIM - 1)) ? '0 : ck + 1'b1;
      if (ck == LOG2D'(DECIM - 1) && win != 2'd3) win <= win + 1'b1;
    end
  end

  assert_phase_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (ck == '0) && past_ok);

  assert_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_fill_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (win >= 2'(ORDER)));

  assert_emit_R5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && ck == '0 && win >= 2'(ORDER)) |-> out_valid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !out_valid) |-> $stable(out_word));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_word <= FULL && out_word >= -FULL));

  assert_reset_R7: assert property (@(posedge clk)
    rst |=> (!out_valid && out_word == '0));
endmodule

bind cic_decimator cic_decimator_chk #(.ORDER(ORDER), .DECIM(DECIM), .W(W)) u_chk (
  .clk(clk), .rst(rst), .out_word(out_word), .out_valid(out_valid)
);

// File: tb/tb_cic_decimator.sv
module tb_cic_decimator;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int D = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_bit = 1'b0;

  logic signed [7:0]  ow1;
  logic signed [13:0] ow2;
  logic signed [19:0] ow3;
  logic ov1, ov2, ov3;

  int checks = 0;
  int fails  = 0;
  int ns     = 0;
  bit hist [0:4095];
  longint hc [1:3][0:189];
  longint last [1:3];

  always #2.5 clk = ~clk;

  cic_decimator #(.ORDER(3), .DECIM(D)) dut (
    .clk(clk), .rst(rst), .in_bit(in_bit), .out_word(ow3), .out_valid(ov3));
  cic_decimator #(.ORDER(1), .DECIM(D)) dut_o1 (
    .clk(clk), .rst(rst), .in_bit(in_bit), .out_word(ow1), .out_valid(ov1));
  cic_decimator #(.ORDER(2), .DECIM(D)) dut_o2 (
    .clk(clk), .rst(rst), .in_bit(in_bit), .out_word(ow2), .out_valid(ov2));

  function automatic longint yref(input int L, input int t);
    longint s = 0;
    for (int j = 0; j <= 63 * L; j++) begin
      if (t - j >= 0) s += hc[L][j] * (hist[t-j] ? 64'sd1 : -64'sd1);
    end
    return s;
  endfunction

  task automatic chk(input int L, input logic v, input longint w);
    logic   ev;
    longint ew;
    ev = (ns > 0) && (ns % D == 0) && (ns / D >= L);
    if (ev) begin
      ew = yref(L, ns - 1);
      last[L] = ew;
    end else begin
      ew = last[L];
    end
    checks++;
    if (v !== ev) begin
      fails++;
      $display("FAIL R4/R5 order=%0d ns=%0d valid act=%0b exp=%0b", L, ns, v, ev);
    end
    checks++;
    if (w != ew) begin
      fails++;
      $display("FAIL %s order=%0d ns=%0d word act=%0d exp=%0d",
               ev ? ((L == 1) ? "R8" : "R2") : "R6", L, ns, w, ew);
    end
  endtask

  task automatic check_all();
    chk(1, ov1, longint'(ow1));
    chk(2, ov2, longint'(ow2));
    chk(3, ov3, longint'(ow3));
  endtask

  task automatic step(input bit b);
    in_bit = b;
    hist[ns] = b;
    ns++;
    @(negedge clk);
    check_all();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    ns = 0;
    for (int l = 1; l <= 3; l++) last[l] = 0;
    checks++;
    if (ov1 || ov2 || ov3 || ow1 != 0 || ow2 != 0 || ow3 != 0) begin
      fails++;
      $display("FAIL R7 reset outputs act=%0d/%0d/%0d exp=0", ow1, ow2, ow3);
    end
  endtask

  task automatic check_extreme(input string tag, input longint sign);
    longint e;
    for (int l = 1; l <= 3; l++) begin
      e = sign * (longint'(1) << (6 * l));
      checks++;
      if (last[l] != e) begin
        fails++;
        $display("FAIL %s order=%0d full-scale act=%0d exp=%0d", tag, l, last[l], e);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int l = 1; l <= 3; l++)
      for (int j = 0; j < 190; j++) hc[l][j] = 0;
    for (int j = 0; j < 64; j++) hc[1][j] = 1;
    for (int l = 2; l <= 3; l++)
      for (int j = 0; j <= 63 * l; j++)
        for (int k = 0; k < 64; k++)
          if (j - k >= 0) hc[l][j] += hc[l-1][j-k];

    do_reset();
    // R1: constant ones reach positive full scale
    for (int i = 0; i < 6 * D; i++) step(1'b1);
    check_extreme("R1", 1);
    // R3: constant zeros reach negative full scale without wrap
    for (int i = 0; i < 6 * D; i++) step(1'b0);
    check_extreme("R3", -1);
    // alternating pattern
    for (int i = 0; i < 6 * D; i++) step(i[0]);
    // random densities
    for (int w = 0; w < 12; w++) begin
      int dens;
      dens = 5 + (w * 9) % 91;
      for (int i = 0; i < D; i++) step(($urandom % 100) < dens);
    end
    // R7: reset in mid-window then restart
    for (int i = 0; i < 23; i++) step($urandom % 2 == 1);
    do_reset();
    for (int i = 0; i < 8 * D; i++) step(($urandom % 4) != 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule